// File: doc/BRIEF.md
# Master Video Timing Generator

This block produces the master timing for an 8-bit component video stream. The stream runs at twice the sample rate, with bytes in the repeating order Cb, Y, Cr, Y. At the default setting one line is 1716 clocks and one frame is 525 lines, split into two fields. When master mode is enabled, the block drives these signals to the upstream pixel source:

- active-low horizontal and vertical sync;
- a half-rate chroma select that toggles on every clock;
- a strobe that marks the Cb byte of each four-byte group;
- an enable that is high exactly where active picture data is expected.

With the chroma select and the Cb strobe, a framestore source can keep the Cb-Y-Cr-Y order locked, so Cb and Cr cannot be swapped. The block also gives two status bits for a status register: an active-low composite sync and a burst flag.

Three counters hold the state:

- a horizontal position counter;
- a line counter, stepped at the end of each line;
- a two-bit sample-phase counter, cleared at the start of each line.

All outputs are decoded from these counter flops. When master mode is off, every counter stays at zero and every output is held inactive. When master mode is enabled again, timing restarts from the first clock of line 1.

Top module: `vtg_master_timing`

## Requirements
- R1: While `rst_n` is low or `master_en` is low, the outputs are at their inactive levels: `hsync_n`=1, `vsync_n`=1, `csync_n`=1, `chroma_sel`=0, `cb_strobe`=0, `pix_en`=0, `burst_flag`=0.
- R2: Count cycles from the first clock edge that samples `master_en` high, with that edge's cycle as N=0. In cycle N the position is hpos = N mod LINE_CLKS and line = (N div LINE_CLKS) mod FRAME_LINES + 1.
- R3: `chroma_sel` is 1 when hpos mod 4 is 0 or 2, and 0 when it is 1 or 3. It therefore changes on every clock while the block runs.
- R4: `cb_strobe` is 1 exactly when hpos mod 4 is 0, which marks the first byte (Cb) of each Cb-Y-Cr-Y group.
- R5: `pix_en` is 1 exactly when both of these hold:
  - hpos >= LINE_CLKS - ACTIVE_CLKS;
  - the line lies in F1_ACT_FIRST..F1_LINES or in F2_ACT_FIRST..FRAME_LINES.
- R6: `hsync_n` is 0 exactly when hpos < HS_CLKS.
- R7: `vsync_n` is 0 exactly when the field line lies in VS_FIRST..VS_LAST. The field line equals the line for lines 1..F1_LINES, and equals line - F1_LINES for later lines.
- R8: `csync_n` is 0 exactly when `hsync_n` or `vsync_n` is 0.
- R9: `burst_flag` is 1 exactly when BURST_FIRST <= hpos <= BURST_LAST, on every line.
- R10: If `master_en` drops, all outputs are inactive from the next cycle on. When it rises again, timing restarts at N=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master-mode enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| chroma_sel | output | 1 | High for chroma byte slots |
| cb_strobe | output | 1 | High for the Cb byte slot |
| pix_en | output | 1 | Active pixel data expected |
| burst_flag | output | 1 | Burst window status |
| csync_n | output | 1 | Composite sync status, active low |

## Verification
The assertions check these on every cycle:

- the counters wrap at the end of each line and at the end of the frame;
- the phase counter advances by one per clock;
- the chroma select alternates on every clock;
- the Cb strobe never appears without the chroma select;
- pixel enable never overlaps a sync tip;
- the counters are zero while master mode is off.

Only the bench's sweeps can show the exact positions of the sync, burst and active windows, and the split of the two fields. The bench compares every output, on every clock, against a position computed arithmetically over whole frames of a reduced line and frame size. It also covers a mid-line disable with restart, and a reset applied during a run.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // inclusive range test used by all window decodes
  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // line number inside its own field, both counted from 1
  function automatic int unsigned field_line(input int unsigned line_no,
                                             input int unsigned f1_lines);
    if (line_no <= f1_lines) return line_no;
    return line_no - f1_lines;
  endfunction

  // active picture line in either field
  function automatic logic active_line(input int unsigned line_no,
                                       input int unsigned f1_first,
                                       input int unsigned f1_last,
                                       input int unsigned f2_first,
                                       input int unsigned f2_last);
    return in_span(line_no, f1_first, f1_last) || in_span(line_no, f2_first, f2_last);
  endfunction

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
  parameter int unsigned LINE_CLKS = 1716,
  parameter int unsigned HW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_en,
  output logic          run,
  output logic [HW-1:0] hpos,
  output logic [1:0]    phase,
  output logic          line_end
);

  logic          run_q;
  logic [HW-1:0] hpos_q;
  logic [1:0]    phase_q;

  assign line_end = run_q && (hpos_q == HW'(LINE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hpos_q  <= '0;
      phase_q <= '0;
    end else if (!master_en) begin
      run_q   <= 1'b0;
      hpos_q  <= '0;
      phase_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (line_end) begin
          hpos_q  <= '0;
          phase_q <= '0;
        end else begin
          hpos_q  <= hpos_q + 1'b1;
          phase_q <= phase_q + 2'd1;
        end
      end
    end
  end

  assign run   = run_q;
  assign hpos  = hpos_q;
  assign phase = phase_q;

  // R2: position wraps to zero after the last clock of a line
  a_r2_hpos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hpos_q == '0));

  // R3: sample phase advances by one on every running clock inside a line
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && master_en && !line_end) |=> (phase_q == $past(phase_q) + 2'd1));

  // R10: disabling parks the horizontal state at zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (!run_q && hpos_q == '0 && phase_q == '0));

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount #(
  parameter int unsigned FRAME_LINES = 525,
  parameter int unsigned LW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_en,
  input  logic          line_end,
  output logic [LW-1:0] line_idx,
  output logic          frame_end
);

  logic [LW-1:0] line_q;

  assign frame_end = line_end && (line_q == LW'(FRAME_LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            line_q <= '0;
    else if (!master_en)   line_q <= '0;
    else if (frame_end)    line_q <= '0;
    else if (line_end)     line_q <= line_q + 1'b1;
  end

  assign line_idx = line_q;

  // R2: the frame wraps to the first line
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && master_en) |=> (line_q == '0));

  // R2: the line counter steps by one at each line end
  a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end && master_en) |=> (line_q == $past(line_q) + 1'b1));

  // R2: the line counter is steady inside a line
  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_end && master_en) |=> $stable(line_q));

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
#(
  parameter int unsigned LINE_CLKS    = 1716,
  parameter int unsigned ACTIVE_CLKS  = 1440,
  parameter int unsigned FRAME_LINES  = 525,
  parameter int unsigned F1_LINES     = 263,
  parameter int unsigned F1_ACT_FIRST = 20,
  parameter int unsigned F2_ACT_FIRST = 283,
  parameter int unsigned HS_CLKS      = 128,
  parameter int unsigned BURST_FIRST  = 140,
  parameter int unsigned BURST_LAST   = 220,
  parameter int unsigned VS_FIRST     = 4,
  parameter int unsigned VS_LAST      = 6,
  parameter int unsigned HW           = 11,
  parameter int unsigned LW           = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] hpos,
  input  logic [LW-1:0] line_idx,
  input  logic [1:0]    phase,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          chroma_sel,
  output logic          cb_strobe,
  output logic          pix_en,
  output logic          burst_flag,
  output logic          csync_n
);

  localparam int unsigned ACT_START = LINE_CLKS - ACTIVE_CLKS;

  int unsigned h, ln, fl;
  logic hs_tip, vs_tip, act_line, act_pix, burst_win;

  always_comb begin
    h         = 32'(hpos);
    ln        = 32'(line_idx) + 1;
    fl        = field_line(ln, F1_LINES);
    hs_tip    = h < HS_CLKS;
    vs_tip    = in_span(fl, VS_FIRST, VS_LAST);
    act_line  = active_line(ln, F1_ACT_FIRST, F1_LINES, F2_ACT_FIRST, FRAME_LINES);
    act_pix   = act_line && (h >= ACT_START);
    burst_win = in_span(h, BURST_FIRST, BURST_LAST);
  end

  assign hsync_n    = !(run && hs_tip);
  assign vsync_n    = !(run && vs_tip);
  assign csync_n    = hsync_n && vsync_n;
  assign chroma_sel = run && !phase[0];
  assign cb_strobe  = run && (phase == 2'd0);
  assign pix_en     = run && act_pix;
  assign burst_flag = run && burst_win;

  // R3: chroma select alternates every clock while running
  a_r3_chroma_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (chroma_sel != $past(chroma_sel)));

  // R4: a Cb slot is always a chroma slot, and never two in a row
  a_r4_cb_is_chroma: assert property (@(posedge clk) disable iff (!rst_n)
    cb_strobe |-> chroma_sel);
  a_r4_cb_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    cb_strobe |=> !cb_strobe);

  // R5: picture data is never requested during a sync tip
  a_r5_pix_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> (hsync_n && vsync_n));

  // R1: idle outputs stay inactive
  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync_n && vsync_n && csync_n && !chroma_sel && !cb_strobe
              && !pix_en && !burst_flag));

endmodule

// File: rtl/vtg_master_timing.sv
module vtg_master_timing #(
  parameter int unsigned LINE_CLKS    = 1716,
  parameter int unsigned ACTIVE_CLKS  = 1440,
  parameter int unsigned FRAME_LINES  = 525,
  parameter int unsigned F1_LINES     = 263,
  parameter int unsigned F1_ACT_FIRST = 20,
  parameter int unsigned F2_ACT_FIRST = 283,
  parameter int unsigned HS_CLKS      = 128,
  parameter int unsigned BURST_FIRST  = 140,
  parameter int unsigned BURST_LAST   = 220,
  parameter int unsigned VS_FIRST     = 4,
  parameter int unsigned VS_LAST      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  output logic hsync_n,
  output logic vsync_n,
  output logic chroma_sel,
  output logic cb_strobe,
  output logic pix_en,
  output logic burst_flag,
  output logic csync_n
);

  localparam int unsigned HW = $clog2(LINE_CLKS);
  localparam int unsigned LW = $clog2(FRAME_LINES);

  logic          run;
  logic [HW-1:0] hpos;
  logic [1:0]    phase;
  logic          line_end;
  logic [LW-1:0] line_idx;
  logic          frame_end;

  vtg_hcount #(.LINE_CLKS(LINE_CLKS), .HW(HW)) u_hcount (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .run(run), .hpos(hpos), .phase(phase), .line_end(line_end)
  );

  vtg_vcount #(.FRAME_LINES(FRAME_LINES), .LW(LW)) u_vcount (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .line_end(line_end), .line_idx(line_idx), .frame_end(frame_end)
  );

  vtg_decode #(
    .LINE_CLKS(LINE_CLKS), .ACTIVE_CLKS(ACTIVE_CLKS), .FRAME_LINES(FRAME_LINES),
    .F1_LINES(F1_LINES), .F1_ACT_FIRST(F1_ACT_FIRST), .F2_ACT_FIRST(F2_ACT_FIRST),
    .HS_CLKS(HS_CLKS), .BURST_FIRST(BURST_FIRST), .BURST_LAST(BURST_LAST),
    .VS_FIRST(VS_FIRST), .VS_LAST(VS_LAST), .HW(HW), .LW(LW)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .run(run), .hpos(hpos), .line_idx(line_idx),
    .phase(phase), .hsync_n(hsync_n), .vsync_n(vsync_n), .chroma_sel(chroma_sel),
    .cb_strobe(cb_strobe), .pix_en(pix_en), .burst_flag(burst_flag), .csync_n(csync_n)
  );

  // R2: a frame ends only on a line end of a running block
  a_r2_frame_end_on_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (line_end && run));

endmodule

// File: tb/tb_vtg_master_timing.sv
`timescale 1ns/1ps
module tb_vtg_master_timing;

  localparam int L   = 48;
  localparam int A   = 32;
  localparam int N   = 21;
  localparam int F1  = 11;
  localparam int F1A = 8;
  localparam int F2A = 19;
  localparam int HS  = 6;
  localparam int BF  = 8;
  localparam int BL  = 12;
  localparam int VF  = 2;
  localparam int VL  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0;
  logic hsync_n, vsync_n, chroma_sel, cb_strobe, pix_en, burst_flag, csync_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vtg_master_timing #(
    .LINE_CLKS(L), .ACTIVE_CLKS(A), .FRAME_LINES(N), .F1_LINES(F1),
    .F1_ACT_FIRST(F1A), .F2_ACT_FIRST(F2A), .HS_CLKS(HS),
    .BURST_FIRST(BF), .BURST_LAST(BL), .VS_FIRST(VF), .VS_LAST(VL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .chroma_sel(chroma_sel), .cb_strobe(cb_strobe),
    .pix_en(pix_en), .burst_flag(burst_flag), .csync_n(csync_n)
  );

  task automatic chk(input string req, input int n, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, n, act, exp);
    end
  endtask

  task automatic chk_idle(input string req, input int n);
    chk({req, " hsync_n"}, n, hsync_n, 1'b1);
    chk({req, " vsync_n"}, n, vsync_n, 1'b1);
    chk({req, " csync_n"}, n, csync_n, 1'b1);
    chk({req, " chroma_sel"}, n, chroma_sel, 1'b0);
    chk({req, " cb_strobe"}, n, cb_strobe, 1'b0);
    chk({req, " pix_en"}, n, pix_en, 1'b0);
    chk({req, " burst_flag"}, n, burst_flag, 1'b0);
  endtask

  // expected outputs for cycle n of a run (R2 position model)
  task automatic chk_pos(input int n);
    int h, ln, fl;
    logic e_hs, e_vs, e_act;
    h  = n % L;
    ln = (n / L) % N + 1;
    fl = (ln > F1) ? (ln - F1) : ln;
    e_hs  = !(h < HS);
    e_vs  = !((fl >= VF) && (fl <= VL));
    e_act = (h >= L - A) && (((ln >= F1A) && (ln <= F1)) || ((ln >= F2A) && (ln <= N)));
    chk("R2/R6 hsync_n", n, hsync_n, e_hs);
    chk("R2/R7 vsync_n", n, vsync_n, e_vs);
    chk("R8 csync_n", n, csync_n, e_hs & e_vs);
    chk("R3 chroma_sel", n, chroma_sel, ((h % 4) == 0) || ((h % 4) == 2));
    chk("R4 cb_strobe", n, cb_strobe, (h % 4) == 0);
    chk("R5 pix_en", n, pix_en, e_act);
    chk("R9 burst_flag", n, burst_flag, (h >= BF) && (h <= BL));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_idle("R1 reset", 0);
    rst_n = 1'b1;
    // R1: out of reset but master mode off
    repeat (3) begin
      @(negedge clk);
      chk_idle("R1 disabled", 0);
    end
    // R2..R9: two full frames plus part of a third
    master_en = 1'b1;
    for (int n = 0; n < 2 * L * N + 100; n++) begin
      @(negedge clk);
      chk_pos(n);
    end
    // R10: drop mid-line, outputs idle from the next cycle
    master_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk_idle("R10 dropped", k);
    end
    // R10: restart from position zero
    master_en = 1'b1;
    for (int n = 0; n < L * N + 60; n++) begin
      @(negedge clk);
      chk_pos(n);
    end
    // R1: reset during a run forces idle at once
    rst_n = 1'b0;
    #1;
    chk_idle("R1 async reset", 0);
    @(negedge clk);
    chk_idle("R1 held reset", 1);
    rst_n = 1'b1;
    for (int n = 0; n < 2 * L; n++) begin
      @(negedge clk);
      chk_pos(n);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule